// File: doc/BRIEF.md
# SPI Mode-3 Frame Master

This block is a serial master for clock-polarity-1, clock-phase-1 transfers. Software-side logic pushes words into an eight-entry transmit queue. While the block is enabled and the queue holds a word, it frames a transfer. It lowers the active-low select and turns on the data-out driver. Half a serial-clock period later it starts toggling SCK. It shifts the word out most significant bit first, changing MOSI on falling edges of SCK and capturing MISO on rising edges.

Frame length runs from 4 to 16 bits, and the SCK half-period is a whole number of system clocks. Both are taken from their inputs when a frame starts. When a frame ends with more words queued, the next word follows at the normal bit rate and select stays low. After the last queued word, SCK rests high for one full serial period before select rises. Each received word leaves on a 16-bit bus, right-aligned, with a single-cycle strobe.

Top module: `spi_m3_master`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `sck` is 1, `ssel_n` is 1, `mosi_oe` is 0 and `busy` is 0.
- R2: A frame starts only on a clock where `en` is 1 and `tx_empty` is 0. On the next cycle `ssel_n` is 0, `mosi_oe` is 1 and `busy` is 1, with `sck` still 1. With `en` at 0, queued words stay queued and the lines stay idle.
- R3: Let H be the half-period latched at frame start: `div`, with 0 taken as 1. The first falling edge of `sck` comes exactly H clocks after `ssel_n` falls, and each later SCK level lasts exactly H clocks.
- R4: Frame bit k, counted from the MSB with k = 0 first, is driven on `mosi` from the k-th falling edge of `sck` until the next falling edge. `miso` is captured on each rising edge.
- R5: The frame length N is `fsize`, with values below 4 taken as 4 and values above 16 taken as 16. The N low bits of the queued word are sent and the upper bits are ignored.
- R6: After the last queued word, `ssel_n` returns to 1 exactly 2H clocks after the rising edge that captures its last bit. `sck` stays 1 during that time and `mosi_oe` drops together with `ssel_n`.
- R7: If `en` is 1 and a word is queued H clocks after the last rising edge of a frame, that word's first bit goes out on a falling edge at that point. `ssel_n` stays 0 in between.
- R8: `rx_valid` is 1 for exactly one cycle: the cycle that follows the rising edge capturing a frame's last bit. In that cycle `rx_data` holds the N captured bits right-aligned, first-captured bit highest, with zeros above.
- R9: The transmit queue holds 8 words and returns them in push order. `tx_empty` is 1 at 0 words and `tx_full` is 1 at 8 words. A push while full is dropped.
- R10: Changes to `div` or `fsize` during a frame do not affect that frame. They apply from the next frame start on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Allows new frames to start |
| div | input | 8 | SCK half-period in system clocks (0 acts as 1) |
| fsize | input | 5 | Frame length in bits (clamped to 4..16) |
| tx_data | input | 16 | Word to queue, right-aligned |
| tx_push | input | 1 | Queue `tx_data` on this clock |
| tx_full | output | 1 | Queue holds 8 words |
| tx_empty | output | 1 | Queue holds no word |
| rx_data | output | 16 | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| busy | output | 1 | Select is asserted |
| sck | output | 1 | Serial clock, rests high |
| ssel_n | output | 1 | Active-low select |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for the MOSI pad |
| miso | input | 1 | Serial data in |

## Verification
The hardest case to reach is the frame boundary where the queue still holds a word at the very clock the last high SCK phase expires. To reach it, several words are pushed in a burst while the first frame is still shifting. The queue is also filled with the block disabled and then enabled, so it drains back-to-back. Those frames mix latched sizes and divider values, including a half-period of one clock, so the chained start happens at different distances from the previous frame's start. Between words, the reference model checks that select never rises and that the new word's first bit appears on the expected falling edge.

// File: rtl/spi_m3_pkg.sv
package spi_m3_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_LOW  = 3'd2,
    ST_HIGH = 3'd3,
    ST_TAIL = 3'd4
  } spi_st_e;

  localparam int MIN_FRAME = 4;
endpackage

// File: rtl/spi_m3_rstsync.sv
module spi_m3_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/spi_m3_fifo.sv
module spi_m3_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_en, rd_en;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign wr_en = push && !full;
  assign rd_en = pop && !empty;
  assign dout  = mem[rd_q];

  always_comb begin
    wr_d  = wr_en ? wrap_inc(wr_q) : wr_q;
    rd_d  = rd_en ? wrap_inc(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (wr_en && !rd_en)      cnt_d = cnt_q + CW'(1);
    else if (!wr_en && rd_en) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q] <= din;
  end
endmodule

// File: rtl/spi_m3_htimer.sv
module spi_m3_htimer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || tick) cnt_d = reload - DIV_W'(1);
    else if (run)        cnt_d = cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_m3_engine.sv
module spi_m3_engine
  import spi_m3_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DIV_W = 8,
  parameter int FS_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic [FS_W-1:0]  fsize,
  input  logic [DW-1:0]    head,
  input  logic             empty,
  input  logic             miso,
  input  logic             tick,
  output logic             pop,
  output logic             restart,
  output logic             run,
  output logic [DIV_W-1:0] reload,
  output logic             sck,
  output logic             ssel_n,
  output logic             mosi,
  output logic             mosi_oe,
  output logic [DW-1:0]    rx_data,
  output logic             rx_valid
);
  spi_st_e          st_q, st_d;
  logic             sck_q, sck_d, ssel_q, ssel_d, oe_q, oe_d, mosi_q, mosi_d;
  logic [DW-1:0]    txsh_q, txsh_d, rxsh_q, rxsh_d, rxd_q, rxd_d;
  logic             rxv_q, rxv_d;
  logic [FS_W-1:0]  bits_q, bits_d;
  logic [DIV_W-1:0] hdiv_q, hdiv_d;
  logic [FS_W-1:0]  fs_cl;
  logic [DIV_W-1:0] div_cl;
  logic [DW-1:0]    aligned;
  logic [DW-1:0]    rx_shift;
  logic             start_ok;
  logic             sh_en, rxd_en;

  assign fs_cl    = (fsize < FS_W'(MIN_FRAME)) ? FS_W'(MIN_FRAME) :
                    (fsize > FS_W'(DW))        ? FS_W'(DW) : fsize;
  assign div_cl   = (div == '0) ? DIV_W'(1) : div;
  assign aligned  = head << (FS_W'(DW) - fs_cl);
  assign rx_shift = {rxsh_q[DW-2:0], miso};
  assign start_ok = en && !empty;
  assign run      = (st_q != ST_IDLE);
  assign reload   = pop ? div_cl : hdiv_q;

  always_comb begin
    st_d    = st_q;
    sck_d   = sck_q;
    ssel_d  = ssel_q;
    oe_d    = oe_q;
    mosi_d  = mosi_q;
    txsh_d  = txsh_q;
    rxsh_d  = rxsh_q;
    rxd_d   = rxd_q;
    rxv_d   = 1'b0;
    bits_d  = bits_q;
    hdiv_d  = hdiv_q;
    pop     = 1'b0;
    restart = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_ok) begin
          pop     = 1'b1;
          restart = 1'b1;
          hdiv_d  = div_cl;
          txsh_d  = aligned;
          bits_d  = fs_cl;
          rxsh_d  = '0;
          ssel_d  = 1'b0;
          oe_d    = 1'b1;
          mosi_d  = 1'b0;
          st_d    = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (tick) begin
          sck_d  = 1'b0;
          mosi_d = txsh_q[DW-1];
          txsh_d = txsh_q << 1;
          bits_d = bits_q - FS_W'(1);
          st_d   = ST_LOW;
        end
      end
      ST_LOW: begin
        if (tick) begin
          sck_d  = 1'b1;
          rxsh_d = rx_shift;
          if (bits_q == '0) begin
            rxd_d = rx_shift;
            rxv_d = 1'b1;
          end
          st_d = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tick) begin
          if (bits_q != '0) begin
            sck_d  = 1'b0;
            mosi_d = txsh_q[DW-1];
            txsh_d = txsh_q << 1;
            bits_d = bits_q - FS_W'(1);
            st_d   = ST_LOW;
          end else if (start_ok) begin
            pop    = 1'b1;
            hdiv_d = div_cl;
            sck_d  = 1'b0;
            mosi_d = aligned[DW-1];
            txsh_d = aligned << 1;
            bits_d = fs_cl - FS_W'(1);
            rxsh_d = '0;
            st_d   = ST_LOW;
          end else begin
            st_d = ST_TAIL;
          end
        end
      end
      ST_TAIL: begin
        if (tick) begin
          ssel_d = 1'b1;
          oe_d   = 1'b0;
          mosi_d = 1'b0;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign sh_en  = (st_q != ST_IDLE) || start_ok;
  assign rxd_en = rxv_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sck_q  <= 1'b1;
      ssel_q <= 1'b1;
      oe_q   <= 1'b0;
      mosi_q <= 1'b0;
      rxv_q  <= 1'b0;
      bits_q <= '0;
      hdiv_q <= DIV_W'(1);
    end else begin
      st_q   <= st_d;
      sck_q  <= sck_d;
      ssel_q <= ssel_d;
      oe_q   <= oe_d;
      mosi_q <= mosi_d;
      rxv_q  <= rxv_d;
      bits_q <= bits_d;
      hdiv_q <= hdiv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsh_q <= '0;
      rxsh_q <= '0;
      rxd_q  <= '0;
    end else begin
      if (sh_en)  txsh_q <= txsh_d;
      if (sh_en)  rxsh_q <= rxsh_d;
      if (rxd_en) rxd_q  <= rxd_d;
    end
  end

  assign sck      = sck_q;
  assign ssel_n   = ssel_q;
  assign mosi     = mosi_q;
  assign mosi_oe  = oe_q;
  assign rx_data  = rxd_q;
  assign rx_valid = rxv_q;
endmodule

// File: rtl/spi_m3_master.sv
module spi_m3_master #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int DIV_W = 8,
  parameter int FS_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic [FS_W-1:0]  fsize,
  input  logic [DW-1:0]    tx_data,
  input  logic             tx_push,
  output logic             tx_full,
  output logic             tx_empty,
  output logic [DW-1:0]    rx_data,
  output logic             rx_valid,
  output logic             busy,
  output logic             sck,
  output logic             ssel_n,
  output logic             mosi,
  output logic             mosi_oe,
  input  logic             miso
);
  logic             rst_ns;
  logic [DW-1:0]    head;
  logic             pop, restart, run, tick;
  logic [DIV_W-1:0] reload;

  spi_m3_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  spi_m3_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_ns),
    .push  (tx_push),
    .din   (tx_data),
    .pop   (pop),
    .dout  (head),
    .empty (tx_empty),
    .full  (tx_full)
  );

  spi_m3_htimer #(.DIV_W(DIV_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_ns),
    .run     (run),
    .restart (restart),
    .reload  (reload),
    .tick    (tick)
  );

  spi_m3_engine #(.DW(DW), .DIV_W(DIV_W), .FS_W(FS_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_ns),
    .en       (en),
    .div      (div),
    .fsize    (fsize),
    .head     (head),
    .empty    (tx_empty),
    .miso     (miso),
    .tick     (tick),
    .pop      (pop),
    .restart  (restart),
    .run      (run),
    .reload   (reload),
    .sck      (sck),
    .ssel_n   (ssel_n),
    .mosi     (mosi),
    .mosi_oe  (mosi_oe),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  assign busy = ~ssel_n;
endmodule

// File: rtl/spi_m3_master_chk.sv
module spi_m3_master_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic ssel_n,
  input logic mosi_oe,
  input logic rx_valid,
  input logic tx_full,
  input logic tx_empty
);
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ssel_n |-> (sck && !mosi_oe));

  // R2
  start_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssel_n) |-> (sck && mosi_oe));

  // R4
  sck_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck) |-> (!ssel_n && !$past(ssel_n)));

  // R6
  tail_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssel_n) |-> (sck && $past(sck) && !mosi_oe));

  // R8
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  rx_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($rose(sck) && !ssel_n));

  // R9
  fifo_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));
endmodule

bind spi_m3_master spi_m3_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sck      (sck),
  .ssel_n   (ssel_n),
  .mosi_oe  (mosi_oe),
  .rx_valid (rx_valid),
  .tx_full  (tx_full),
  .tx_empty (tx_empty)
);

// File: tb/sim_spi_m3_master.sv
module sim_spi_m3_master;
  logic        clk = 1'b0;
  logic        rst_n, en, tx_push, miso;
  logic [7:0]  div;
  logic [4:0]  fsize;
  logic [15:0] tx_data, rx_data;
  logic        tx_full, tx_empty, rx_valid, busy, sck, ssel_n, mosi, mosi_oe;

  always #10 clk = ~clk;

  spi_m3_master u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .div(div), .fsize(fsize),
    .tx_data(tx_data), .tx_push(tx_push), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .sck(sck),
    .ssel_n(ssel_n), .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0, cmp_on = 0;

  // reference model state
  bit          m_act = 0;
  int          m_t = 0, m_H = 1, m_n = 8;
  logic [15:0] m_word = '0, m_sword = '0, m_lfsr = 16'hACE1;
  logic [15:0] q[$];
  bit          full_pre;
  int          u, k, span;
  bit          inbit, e_sck, e_rxv;
  string       tag;

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic void m_start();
    m_word = q.pop_front();
    m_H    = (div == 0) ? 1 : int'(div);
    m_n    = (fsize < 4) ? 4 : (fsize > 16) ? 16 : int'(fsize);
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    m_sword = m_lfsr;
  endfunction

  // model steps on the same edge as the design
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
    if (cmp_on) begin
      full_pre = (q.size() == 8);
      if (!m_act) begin
        if (en && q.size() > 0) begin m_start(); m_act = 1; m_t = 0; end
      end else begin
        m_t++;
        if (m_t == 2*m_n*m_H + m_H && en && q.size() > 0) begin
          m_start(); m_t = m_H;
        end else if (m_t == 2*m_n*m_H + 2*m_H) begin
          m_act = 0;
        end
      end
      if (tx_push && !full_pre) q.push_back(tx_data);
    end
  end

  // compare away from the active edge, and drive the slave data line
  always @(negedge clk) begin
    span  = 2*m_n*m_H;
    inbit = m_act && m_t >= m_H && m_t < span + m_H;
    u     = m_t - m_H;
    k     = inbit ? u / (2*m_H) : 0;
    miso  = inbit ? m_sword[m_n-1-k] : 1'b0;
    if (cmp_on && !done) begin
      e_sck = !(inbit && (u % (2*m_H)) < m_H);
      e_rxv = m_act && m_t == span;
      if (!m_act) tag = "R1";
      else if (m_t < m_H) tag = "R2";
      else if (m_t >= span + m_H) tag = "R6";
      else tag = "R7";
      chk(ssel_n == !m_act, tag, ssel_n, !m_act);
      chk(mosi_oe == m_act && busy == m_act, m_act ? "R2" : "R1", {mosi_oe, busy}, {m_act, m_act});
      chk(sck == e_sck, (m_act && m_t < 2*m_H) ? "R3" : "R4", sck, e_sck);
      if (inbit) chk(mosi == m_word[m_n-1-k], "R4", mosi, m_word[m_n-1-k]);
      chk(rx_valid == e_rxv, "R8", rx_valid, e_rxv);
      if (e_rxv)
        chk(rx_data == (m_sword & 16'((32'h1 << m_n) - 1)), "R8", rx_data,
            m_sword & 16'((32'h1 << m_n) - 1));
      chk(tx_empty == (q.size() == 0) && tx_full == (q.size() == 8), "R9",
          {tx_full, tx_empty}, {q.size() == 8, q.size() == 0});
    end
  end

  task automatic push(input logic [15:0] d);
    tx_data = d; tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_act || q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b1; en = 1'b0; tx_push = 1'b0; tx_data = '0; div = 8'd2; fsize = 5'd8;
    #2 rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(sck && ssel_n && !mosi_oe && !busy && !rx_valid, "R1",
        {sck, ssel_n, mosi_oe, busy, rx_valid}, 5'b11000);
    chk(tx_empty && !tx_full, "R9", {tx_full, tx_empty}, 2'b01);
    cmp_on = 1;

    // R2: queued word waits while disabled
    push(16'hA5C3);
    repeat (30) @(negedge clk);
    en = 1'b1;
    wait_idle();

    // R7: burst of full-size words, one-clock half-period
    div = 8'd1; fsize = 5'd16;
    push(16'h8001); push(16'h7E5A); push(16'hC3F0);
    wait_idle();

    // R5: sizes below and above the range are clamped
    div = 8'd3; fsize = 5'd3; push(16'hFFF5); wait_idle();
    div = 8'd1; fsize = 5'd20; push(16'h1234); wait_idle();
    // R3: divider value zero acts as one
    div = 8'd0; fsize = 5'd4; push(16'h000B); wait_idle();

    // R10: settings changed mid-frame do not affect the running frame
    div = 8'd2; fsize = 5'd12; push(16'h0ABC);
    repeat (6) @(negedge clk);
    fsize = 5'd5; div = 8'd7;
    wait_idle();

    // R9: fill while disabled, overfill, then drain back-to-back
    en = 1'b0; div = 8'd1; fsize = 5'd6;
    for (int i = 0; i < 10; i++) push(16'h0100 + 16'(i * 7));
    chk(tx_full, "R9", tx_full, 1);
    en = 1'b1;
    wait_idle();

    // R7 with R10: second word starts with its own size and divider
    div = 8'd2; fsize = 5'd6; push(16'h002D);
    repeat (3) @(negedge clk);
    fsize = 5'd10; div = 8'd1; push(16'h0333);
    wait_idle();

    finish_run();
  end
endmodule